// File: doc/BRIEF.md
# Controller Reset and Clock Bring-up Sequencer

This block orders the reset and power-up of a serial-link controller and its PHY. On a start request it first makes the controller safe to configure. If an earlier boot stage left the link running, which shows as both the reference-clock enable and the training enable being set on entry, the block forces the link state machine back to its detect state and only then turns training off. It then powers the PHY down and gates the reference clock.

After that teardown the block powers the PHY back up. It waits a fixed number of cycles before it enables the reference clock, waits again for the clocks to settle, and holds the endpoint reset low for a further interval before it releases it. It then reports ready and enables link training. A shutdown request runs the same teardown and stops with the PHY powered down, so that the next boot finds the link down.

One down-counter times all three waits. It is loaded with cycle counts given as parameters, so a bench can use short values.

Top module: `bringup_seq`

## Requirements
- R1: While `rst` is high, at every clock edge: `ready`=0, `ep_rst_n`=0, `force_link`=0 and `link_state`=LINK_STATE_INIT, and `refclk_en`/`train_en` copy `boot_refclk_on`/`boot_train_on`.
- R2: Left-active start. If `refclk_en` and `train_en` are both 1 when a start or shutdown is accepted at edge E0, then at E1 `force_link` becomes 1 and `link_state` becomes 0. At E2 `train_en` becomes 0. At E3 `phy_pd` becomes 1 and `refclk_en` becomes 0. `link_state` changes only to 0, and only when `force_link` is 1.
- R3: Other start. If `refclk_en` and `train_en` are not both set at E0, no force takes place: `force_link` and `link_state` keep their values. `phy_pd` becomes 1 and `refclk_en` becomes 0 at E1.
- R4: One edge after `phy_pd` is set during a start, `phy_pd` returns to 0.
- R5: `refclk_en` rises exactly PD_WAIT_CYC edges after `phy_pd` falls, and never rises while `phy_pd` is 1.
- R6: `ep_rst_n`, `ready` and `train_en` all rise together, exactly SETTLE_CYC+EPRST_CYC edges after `refclk_en` rises. From power-on, `ep_rst_n` stays 0 until that point.
- R7: On a later run, `ep_rst_n` goes low SETTLE_CYC edges after `refclk_en` rises and stays low for exactly EPRST_CYC edges.
- R8: A shutdown while `ready` is 1 clears `ready` at the next edge and runs the R2 teardown. It ends with `phy_pd`=1, `refclk_en`=0, `train_en`=0 and `force_link` still 1, and the block then waits with no power-up.
- R9: Start and shutdown are ignored while a sequence is in progress, and start is ignored while `ready` is 1.
- R10: If start and shutdown are both accepted together while idle, the shutdown wins: the block stops after the power-down, and `refclk_en` and `ready` stay 0.
- R11: `force_link` clears at the edge where `phy_pd` is released, and `link_state` stays 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to tear down and bring up |
| shutdown | input | 1 | Request to tear down and stay down |
| boot_refclk_on | input | 1 | Reference-clock enable as left by the earlier stage, loaded during reset |
| boot_train_on | input | 1 | Training enable as left by the earlier stage, loaded during reset |
| phy_pd | output | 1 | PHY power-down/test control |
| refclk_en | output | 1 | Reference-clock enable |
| train_en | output | 1 | Link-training enable |
| force_link | output | 1 | Force-link control to the link state machine |
| link_state | output | 6 | Forced link-state field, cleared to 0 while forcing |
| ep_rst_n | output | 1 | Active-low endpoint reset |
| ready | output | 1 | Bring-up finished |

## Verification
Several orderings are checked by the assertions on every cycle: training never falls unless force is set with a zero state field, the reference clock never rises under power-down, and the endpoint reset releases together with ready. The assertions also check that ready holds until a shutdown and that the state field only moves to zero. The exact gaps between steps are shown only by the bench scenarios. Those are the power-down-to-clock wait, the settle wait and the endpoint pulse length. The same holds for the choice between the teardown path and the direct path, the ignored requests while the block is busy, and shutdown taking priority over start.

// File: rtl/bup_pkg.sv
package bup_pkg;

    localparam int unsigned LSW = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FORCE,
        S_DISABLE,
        S_ASSERT,
        S_PWRUP,
        S_WPD,
        S_WSET,
        S_WEP,
        S_READY
    } state_t;

    typedef struct packed {
        logic           phy_pd;
        logic           refclk_en;
        logic           train_en;
        logic           force_link;
        logic [LSW-1:0] link_state;
        logic           ep_rel;
        logic           ready;
    } ctrl_t;

    function automatic logic left_active(input ctrl_t c);
        return c.refclk_en & c.train_en;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bup_timer.sv
module bup_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/bup_fsm.sv
module bup_fsm
    import bup_pkg::*;
#(
    parameter bit             HAS_EP  = 1'b1,
    parameter int unsigned    CW      = 8,
    parameter logic [CW-1:0]  LD_PD   = '0,
    parameter logic [CW-1:0]  LD_SET  = '0,
    parameter logic [CW-1:0]  LD_EP   = '0,
    parameter logic [LSW-1:0] LS_INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          shutdown,
    input  logic          boot_refclk_on,
    input  logic          boot_train_on,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output ctrl_t         ctrl
);
    state_t st;
    logic   shut_req;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_PWRUP: begin
                tmr_load = 1'b1;
                tmr_val  = LD_PD;
            end
            S_WPD: if (tmr_zero) begin
                tmr_load = 1'b1;
                tmr_val  = LD_SET;
            end
            S_WSET: if (tmr_zero && HAS_EP) begin
                tmr_load = 1'b1;
                tmr_val  = LD_EP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st                <= S_IDLE;
            shut_req          <= 1'b0;
            ctrl.phy_pd       <= 1'b0;
            ctrl.refclk_en    <= boot_refclk_on;
            ctrl.train_en     <= boot_train_on;
            ctrl.force_link   <= 1'b0;
            ctrl.link_state   <= LS_INIT;
            ctrl.ep_rel       <= 1'b0;
            ctrl.ready        <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start || shutdown) begin
                    shut_req <= shutdown;
                    st       <= left_active(ctrl) ? S_FORCE : S_ASSERT;
                end
                S_READY: if (shutdown) begin
                    ctrl.ready <= 1'b0;
                    shut_req   <= 1'b1;
                    st         <= left_active(ctrl) ? S_FORCE : S_ASSERT;
                end
                S_FORCE: begin
                    ctrl.force_link <= 1'b1;
                    ctrl.link_state <= '0;
                    st              <= S_DISABLE;
                end
                S_DISABLE: begin
                    ctrl.train_en <= 1'b0;
                    st            <= S_ASSERT;
                end
                S_ASSERT: begin
                    ctrl.phy_pd    <= 1'b1;
                    ctrl.refclk_en <= 1'b0;
                    st             <= shut_req ? S_IDLE : S_PWRUP;
                end
                S_PWRUP: begin
                    ctrl.phy_pd     <= 1'b0;
                    ctrl.force_link <= 1'b0;
                    st              <= S_WPD;
                end
                S_WPD: if (tmr_zero) begin
                    ctrl.refclk_en <= 1'b1;
                    st             <= S_WSET;
                end
                S_WSET: if (tmr_zero) begin
                    if (HAS_EP) begin
                        ctrl.ep_rel <= 1'b0;
                        st          <= S_WEP;
                    end else begin
                        ctrl.ready    <= 1'b1;
                        ctrl.train_en <= 1'b1;
                        st            <= S_READY;
                    end
                end
                S_WEP: if (tmr_zero) begin
                    ctrl.ep_rel   <= 1'b1;
                    ctrl.ready    <= 1'b1;
                    ctrl.train_en <= 1'b1;
                    st            <= S_READY;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
    import bup_pkg::*;
#(
    parameter int unsigned    PD_WAIT_CYC     = 1000,
    parameter int unsigned    SETTLE_CYC      = 20000,
    parameter int unsigned    EPRST_CYC       = 10000000,
    parameter bit             HAS_EP          = 1'b1,
    parameter logic [LSW-1:0] LINK_STATE_INIT = 6'h11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           shutdown,
    input  logic           boot_refclk_on,
    input  logic           boot_train_on,
    output logic           phy_pd,
    output logic           refclk_en,
    output logic           train_en,
    output logic           force_link,
    output logic [LSW-1:0] link_state,
    output logic           ep_rst_n,
    output logic           ready
);
    localparam int unsigned MAXC = max3(PD_WAIT_CYC, SETTLE_CYC, EPRST_CYC);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_PD  = CW'(PD_WAIT_CYC - 1);
    localparam logic [CW-1:0] LD_SET = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] LD_EP  = CW'(EPRST_CYC - 1);

    logic          tmr_load;
    logic          tmr_zero;
    logic [CW-1:0] tmr_val;
    ctrl_t         ctrl;

    bup_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bup_fsm #(
        .HAS_EP  (HAS_EP),
        .CW      (CW),
        .LD_PD   (LD_PD),
        .LD_SET  (LD_SET),
        .LD_EP   (LD_EP),
        .LS_INIT (LINK_STATE_INIT)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .shutdown       (shutdown),
        .boot_refclk_on (boot_refclk_on),
        .boot_train_on  (boot_train_on),
        .tmr_zero       (tmr_zero),
        .tmr_load       (tmr_load),
        .tmr_val        (tmr_val),
        .ctrl           (ctrl)
    );

    assign phy_pd     = ctrl.phy_pd;
    assign refclk_en  = ctrl.refclk_en;
    assign train_en   = ctrl.train_en;
    assign force_link = ctrl.force_link;
    assign link_state = ctrl.link_state;
    assign ready      = ctrl.ready;

    generate
        if (HAS_EP) begin : g_ep
            assign ep_rst_n = ctrl.ep_rel;
        end else begin : g_no_ep
            assign ep_rst_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/bringup_seq_chk.sv
module bringup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       shutdown,
    input logic       phy_pd,
    input logic       refclk_en,
    input logic       train_en,
    input logic       force_link,
    input logic [5:0] link_state,
    input logic       ep_rst_n,
    input logic       ready
);
    AST_RESET_OUTPUTS: assert property (@(posedge clk)
        rst |=> (!ready && !ep_rst_n && !force_link)); // R1

    AST_TRAIN_OFF_AFTER_FORCE: assert property (@(posedge clk) disable iff (rst)
        $fell(train_en) |-> (force_link && link_state == 6'd0)); // R2

    AST_STATE_ONLY_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$stable(link_state) |-> (force_link && link_state == 6'd0)); // R2

    AST_REFCLK_NOT_IN_PD: assert property (@(posedge clk) disable iff (rst)
        $rose(refclk_en) |-> !phy_pd); // R5

    AST_EP_RELEASE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_rst_n) |-> (ready && train_en && refclk_en && !phy_pd)); // R6

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ready && !shutdown) |=> ready); // R9

    AST_FORCE_STATE_ZERO: assert property (@(posedge clk) disable iff (rst)
        force_link |-> (link_state == 6'd0)); // R11
endmodule

bind bringup_seq bringup_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .shutdown   (shutdown),
    .phy_pd     (phy_pd),
    .refclk_en  (refclk_en),
    .train_en   (train_en),
    .force_link (force_link),
    .link_state (link_state),
    .ep_rst_n   (ep_rst_n),
    .ready      (ready)
);

// File: tb/bringup_seq_test.sv
`timescale 1ns/1ps
module bringup_seq_test;
    localparam int T_PD  = 5;
    localparam int T_SET = 12;
    localparam int T_EP  = 20;
    localparam logic [5:0] LS_INIT = 6'h11;
    localparam int LIM = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic shutdown = 1'b0;
    logic boot_refclk_on = 1'b0;
    logic boot_train_on = 1'b0;
    logic phy_pd, refclk_en, train_en, force_link, ep_rst_n, ready;
    logic [5:0] link_state;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bringup_seq #(
        .PD_WAIT_CYC(T_PD), .SETTLE_CYC(T_SET), .EPRST_CYC(T_EP),
        .HAS_EP(1'b1), .LINK_STATE_INIT(LS_INIT)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .shutdown(shutdown),
        .boot_refclk_on(boot_refclk_on), .boot_train_on(boot_train_on),
        .phy_pd(phy_pd), .refclk_en(refclk_en), .train_en(train_en),
        .force_link(force_link), .link_state(link_state),
        .ep_rst_n(ep_rst_n), .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int base_of(input bit left);
        return left ? 4 : 2;
    endfunction

    function automatic int exp_ready(input bit left);
        return base_of(left) + T_PD + T_SET + T_EP;
    endfunction

    task automatic do_reset(input bit br, input bit bt);
        @(negedge clk);
        boot_refclk_on = br;
        boot_train_on  = bt;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready", int'(ready), 0);
        chk("R1 ep_rst_n", int'(ep_rst_n), 0);
        chk("R1 force_link", int'(force_link), 0);
        chk("R1 link_state", int'(link_state), int'(LS_INIT));
        chk("R1 refclk_en", int'(refclk_en), int'(br));
        chk("R1 train_en", int'(bt), int'(train_en));
        rst = 1'b0;
        repeat ($urandom_range(1, 4)) @(negedge clk);
    endtask

    task automatic run_seq(input bit left, input bit rerun);
        int k;
        int t_force, t_troff, t_pdon, t_pdoff, t_ref, t_epf, t_rdy;
        int ep_early;
        logic [5:0] ls0;
        t_force = -1; t_troff = -1; t_pdon = -1; t_pdoff = -1;
        t_ref = -1; t_epf = -1; t_rdy = -1; ep_early = 0;
        ls0 = link_state;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!ready && k < LIM) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            shutdown = 1'b0;
            if (force_link && t_force < 0) t_force = k;
            if (!train_en && t_troff < 0) t_troff = k;
            if (phy_pd && t_pdon < 0) t_pdon = k;
            if (t_pdon >= 0 && !phy_pd && t_pdoff < 0) t_pdoff = k;
            if (t_pdoff >= 0 && refclk_en && t_ref < 0) t_ref = k;
            if (t_ref >= 0 && !ep_rst_n && t_epf < 0) t_epf = k;
            if (ready && t_rdy < 0) t_rdy = k;
            if (!ready && ep_rst_n && !rerun) ep_early++;
            if (!ready && k >= 1 && k <= base_of(left) + T_PD - 1
                && $urandom_range(0, 2) == 0) begin
                if ($urandom_range(0, 1) == 0) start = 1'b1;
                else shutdown = 1'b1;
            end
        end
        start = 1'b0;
        shutdown = 1'b0;
        if (!rerun) begin
            chk("R2/R3 force_link rise cycle", t_force, left ? 1 : -1);
            if (left) begin
                chk("R2 train_en off cycle", t_troff, 2);
                chk("R2 link_state cleared", int'(link_state), 0);
            end else begin
                chk("R3 link_state untouched", int'(link_state), int'(ls0));
            end
            chk("R6 ep_rst_n held low before ready", ep_early, 0);
        end
        chk("R2/R3 phy_pd set cycle", t_pdon, base_of(left) - 1);
        chk("R4 phy_pd release cycle", t_pdoff, base_of(left));
        chk("R5 refclk_en rise cycle", t_ref, base_of(left) + T_PD);
        chk("R6 ready cycle (R9 busy requests ignored)", t_rdy, exp_ready(left));
        chk("R6 ep_rst_n released", int'(ep_rst_n), 1);
        chk("R6 train_en at ready", int'(train_en), 1);
        chk("R11 force_link cleared", int'(force_link), 0);
        if (rerun) begin
            chk("R7 ep_rst_n fall cycle", t_epf, base_of(left) + T_PD + T_SET);
            chk("R7 ep_rst_n low width", t_rdy - t_epf, T_EP);
        end
    endtask

    task automatic start_in_ready();
        int bad;
        bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (!ready || phy_pd || !refclk_en) bad++;
        end
        chk("R9 start in ready ignored", bad, 0);
    endtask

    task automatic shutdown_from_ready();
        int bad;
        bad = 0;
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0;
        chk("R8 ready cleared", int'(ready), 0);
        @(negedge clk);
        chk("R8 force_link set", int'(force_link), 1);
        chk("R8 link_state zero", int'(link_state), 0);
        @(negedge clk);
        chk("R8 train_en off", int'(train_en), 0);
        chk("R8 refclk_en still on", int'(refclk_en), 1);
        @(negedge clk);
        chk("R8 phy_pd set", int'(phy_pd), 1);
        chk("R8 refclk_en off", int'(refclk_en), 0);
        repeat (30) begin
            @(negedge clk);
            if (!phy_pd || refclk_en || ready || train_en || !force_link) bad++;
        end
        chk("R8 stays down", bad, 0);
    endtask

    task automatic both_in_idle();
        int bad;
        bad = 0;
        start = 1'b1;
        shutdown = 1'b1;
        @(negedge clk);
        start = 1'b0;
        shutdown = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (refclk_en || ready) bad++;
        end
        chk("R10 shutdown wins", bad, 0);
        chk("R10 phy_pd down", int'(phy_pd), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int it = 0; it < 6; it++) begin
            bit br, bt;
            int combo;
            combo = (it < 4) ? it : int'($urandom_range(0, 3));
            br = combo[0];
            bt = combo[1];
            do_reset(br, bt);
            run_seq(br && bt, 1'b0);
            start_in_ready();
            shutdown_from_ready();
            both_in_idle();
            run_seq(1'b0, 1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule